// File: doc/BRIEF.md
# Frame and Multiframe Sync Aligner

The aligner derives two low-rate timing pulses from a clock that is already frequency-locked to a reference. A frame pulse runs at either 8 kHz or once per second. A multiframe pulse runs at either 2 kHz or once per second. A single counter chain, advanced only on the cycles where `tick_en` is high, counts locked-clock ticks within a frame and frames within a second. Both pulses are decoded from that chain, so each multiframe pulse falls on a frame boundary.

A companion sync input arrives at a selectable low rate: 8 kHz, 4 kHz, 2 kHz or 1 pulse per second. Its rising edges realign the counter chain, so the outputs take their phase from the sync input. Their frequency still comes from the locked clock. The loop therefore never has to track the slow pulse with a narrow bandwidth.

A three-state machine controls realignment:
- `ST_ACQ` waits after reset for the first edge. That edge always loads the chain and moves the machine to `ST_TRACK`.
- In `ST_TRACK`, an edge within one tick of the expected position leaves the chain alone. Any other edge reloads it.
- If no edge arrives within one sync period plus a slack, `ST_TRACK` moves to `ST_LOST`. There the chain free-runs and `sync_lost` is raised.
- An edge in `ST_LOST` reloads the chain unconditionally and returns the machine to `ST_TRACK`.

Top module: `frame_sync_aligner`

## Requirements
- R1: While `rst_n` is low, `fr_pulse`, `mf_pulse` and `sync_lost` are 0. The chain restarts at phase zero, so the first tick after reset yields a frame pulse (with `fr_pps`=0) and a multiframe pulse (with `mf_pps`=0).
- R2: State and outputs change only on cycles where `tick_en` is high. Each output pulse lasts exactly one tick, from one enabled cycle to the next.
- R3: With `fr_pps`=0, `fr_pulse` fires at tick 0 of every frame (8 kHz; a frame is TICKS_PER_FRAME ticks). With `fr_pps`=1, it fires only at tick 0 of frame 0 (once per second).
- R4: With `mf_pps`=0, `mf_pulse` fires at tick 0 of every frame whose index is a multiple of 4 (2 kHz). With `mf_pps`=1, it fires at tick 0 of frame 0. The chain is shared, so a 2 kHz pulse always coincides with an 8 kHz frame pulse, and a once-per-second frame pulse always coincides with a multiframe pulse.
- R5: `sync_rate` gives the sync period in frames: 0 = 1 frame (8 kHz), 1 = 2 frames (4 kHz), 2 = 4 frames (2 kHz), 3 = FRAMES_PER_SEC frames (1 PPS). It sets both the expected edge position and the loss deadline.
- R6: A rising edge of `sync_in` is detected only on a tick. In `ST_ACQ`, the first such edge loads the chain to tick 0 of frame 0. Both pulses then appear in the cycle after that tick.
- R7: In `ST_TRACK`, the chain is left unchanged if an edge is at most one tick early or late against the sync period. An edge further off reloads the chain, as in R6.
- R8: In `ST_TRACK`, if no edge arrives on ticks 1 to P+SLACK after the last edge (P = sync period in ticks), `sync_lost` rises after tick P+SLACK+1. The chain keeps free-running.
- R9: If an edge arrives on the same tick as the loss deadline, the edge wins. The machine stays in `ST_TRACK`, applies the R7 rule and keeps `sync_lost` low.
- R10: An edge in `ST_LOST` always reloads the chain, even when it is within one tick of the free-running phase. It also clears `sync_lost` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One cycle per locked-clock tick |
| sync_in | input | 1 | Low-rate sync input, rising edge marks phase |
| sync_rate | input | 2 | Sync input rate code (R5) |
| fr_pps | input | 1 | Frame output rate: 0 = 8 kHz, 1 = once per second |
| mf_pps | input | 1 | Multiframe output rate: 0 = 2 kHz, 1 = once per second |
| fr_pulse | output | 1 | Frame sync pulse |
| mf_pulse | output | 1 | Multiframe sync pulse |
| sync_lost | output | 1 | High while the sync input is missing |

## Verification
Two pairs of events can land on the same tick. The loss deadline can meet a late sync edge, and a reloading edge can arrive one tick after a scheduled frame pulse. The bench places an edge exactly P+SLACK+1 ticks after the previous one and expects a reload pulse with `sync_lost` still low. It also places an edge one tick after a free-running pulse while the machine is in the lost state, and expects two adjacent pulses followed by a period measured from the second. Off-by-one errors in the gap counter or the tolerance window move these pulses by one cycle, and the per-cycle scoreboard flags that.

// File: rtl/fms_pkg.sv
package fms_pkg;

    typedef enum logic [1:0] {
        ST_ACQ   = 2'd0,
        ST_TRACK = 2'd1,
        ST_LOST  = 2'd2
    } fms_state_t;

    typedef enum logic [1:0] {
        RATE_8K = 2'd0,
        RATE_4K = 2'd1,
        RATE_2K = 2'd2,
        RATE_1S = 2'd3
    } sync_rate_t;

endpackage

// File: rtl/fms_edge_det.sv
module fms_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic sync_in,
    output logic sync_edge
);

    logic prev_q;

    // Reset to 1 so a level already high at reset is not an edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else if (tick_en) begin
            prev_q <= sync_in;
        end
    end

    assign sync_edge = tick_en && sync_in && !prev_q;

endmodule

// File: rtl/fms_gap_watch.sv
module fms_gap_watch
    import fms_pkg::*;
#(
    parameter int TICKS_PER_FRAME = 16,
    parameter int FRAMES_PER_SEC  = 8000,
    parameter int SLACK_TICKS     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       sync_edge,
    input  sync_rate_t rate,
    output logic       timeout
);

    localparam int GW = $clog2(TICKS_PER_FRAME * FRAMES_PER_SEC + SLACK_TICKS + 2);
    localparam logic [GW-1:0] LIM_8K  = GW'(TICKS_PER_FRAME + SLACK_TICKS);
    localparam logic [GW-1:0] LIM_4K  = GW'(2 * TICKS_PER_FRAME + SLACK_TICKS);
    localparam logic [GW-1:0] LIM_2K  = GW'(4 * TICKS_PER_FRAME + SLACK_TICKS);
    localparam logic [GW-1:0] LIM_1S  = GW'(TICKS_PER_FRAME * FRAMES_PER_SEC + SLACK_TICKS);
    localparam logic [GW-1:0] GAP_MAX = '1;

    logic [GW-1:0] gap_q;
    logic [GW-1:0] limit;

    always_comb begin
        unique case (rate)
            RATE_8K: limit = LIM_8K;
            RATE_4K: limit = LIM_4K;
            RATE_2K: limit = LIM_2K;
            RATE_1S: limit = LIM_1S;
        endcase
    end

    // Ticks elapsed since the last accepted edge; saturates.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (tick_en) begin
            if (sync_edge) begin
                gap_q <= '0;
            end else if (gap_q != GAP_MAX) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    assign timeout = tick_en && (gap_q >= limit);

endmodule

// File: rtl/fms_phase_chain.sv
module fms_phase_chain
    import fms_pkg::*;
#(
    parameter int TICKS_PER_FRAME = 16,
    parameter int FRAMES_PER_SEC  = 8000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       load,
    input  logic       fr_pps,
    input  logic       mf_pps,
    input  sync_rate_t rate,
    output logic       in_window,
    output logic       fr_pulse,
    output logic       mf_pulse
);

    localparam int TW = (TICKS_PER_FRAME > 1) ? $clog2(TICKS_PER_FRAME) : 1;
    localparam int FW = $clog2(FRAMES_PER_SEC);
    localparam logic [TW-1:0] TICK_LAST  = TW'(TICKS_PER_FRAME - 1);
    localparam logic [FW-1:0] FRAME_LAST = FW'(FRAMES_PER_SEC - 1);

    logic [TW-1:0] tick_q, eff_tick;
    logic [FW-1:0] frm_q, eff_frm;
    logic          fr_q, mf_q;
    logic          sub_first, sub_last;

    // Position of the current frame within one sync period.
    always_comb begin
        unique case (rate)
            RATE_8K: begin sub_first = 1'b1;                sub_last = 1'b1;                end
            RATE_4K: begin sub_first = !frm_q[0];           sub_last = frm_q[0];            end
            RATE_2K: begin sub_first = (frm_q[1:0] == 2'd0); sub_last = (frm_q[1:0] == 2'd3); end
            RATE_1S: begin sub_first = (frm_q == '0);       sub_last = (frm_q == FRAME_LAST); end
        endcase
    end

    // Edge is tolerated at expected position, one tick late or one tick early.
    assign in_window = (sub_first && (tick_q <= TW'(1))) ||
                       (sub_last && (tick_q == TICK_LAST));

    assign eff_tick = load ? '0 : tick_q;
    assign eff_frm  = load ? '0 : frm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
            frm_q  <= '0;
            fr_q   <= 1'b0;
            mf_q   <= 1'b0;
        end else if (tick_en) begin
            fr_q <= (eff_tick == '0) && (fr_pps ? (eff_frm == '0) : 1'b1);
            mf_q <= (eff_tick == '0) && (mf_pps ? (eff_frm == '0) : (eff_frm[1:0] == 2'd0));
            if (eff_tick == TICK_LAST) begin
                tick_q <= '0;
                frm_q  <= (eff_frm == FRAME_LAST) ? '0 : eff_frm + 1'b1;
            end else begin
                tick_q <= eff_tick + 1'b1;
                frm_q  <= eff_frm;
            end
        end
    end

    assign fr_pulse = fr_q;
    assign mf_pulse = mf_q;

endmodule

// File: rtl/frame_sync_aligner.sv
module frame_sync_aligner
    import fms_pkg::*;
#(
    parameter int TICKS_PER_FRAME = 16,
    parameter int FRAMES_PER_SEC  = 8000,
    parameter int SLACK_TICKS     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       sync_in,
    input  logic [1:0] sync_rate,
    input  logic       fr_pps,
    input  logic       mf_pps,
    output logic       fr_pulse,
    output logic       mf_pulse,
    output logic       sync_lost
);

    sync_rate_t rate;
    fms_state_t state_q, next_state;
    logic       sync_edge;
    logic       timeout;
    logic       in_window;
    logic       load;
    logic       lost_q;

    assign rate = sync_rate_t'(sync_rate);

    fms_edge_det u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .sync_in   (sync_in),
        .sync_edge (sync_edge)
    );

    fms_gap_watch #(
        .TICKS_PER_FRAME (TICKS_PER_FRAME),
        .FRAMES_PER_SEC  (FRAMES_PER_SEC),
        .SLACK_TICKS     (SLACK_TICKS)
    ) u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .sync_edge (sync_edge),
        .rate      (rate),
        .timeout   (timeout)
    );

    fms_phase_chain #(
        .TICKS_PER_FRAME (TICKS_PER_FRAME),
        .FRAMES_PER_SEC  (FRAMES_PER_SEC)
    ) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .load      (load),
        .fr_pps    (fr_pps),
        .mf_pps    (mf_pps),
        .rate      (rate),
        .in_window (in_window),
        .fr_pulse  (fr_pulse),
        .mf_pulse  (mf_pulse)
    );

    // Next state and chain reload decision.
    always_comb begin
        next_state = state_q;
        load       = 1'b0;
        unique case (state_q)
            ST_ACQ: begin
                if (sync_edge) begin
                    next_state = ST_TRACK;
                    load       = 1'b1;
                end
            end
            ST_TRACK: begin
                if (sync_edge) begin
                    load = !in_window;
                end else if (timeout) begin
                    next_state = ST_LOST;
                end
            end
            ST_LOST: begin
                if (sync_edge) begin
                    next_state = ST_TRACK;
                    load       = 1'b1;
                end
            end
            default: begin
                next_state = ST_ACQ;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACQ;
        end else begin
            state_q <= next_state;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lost_q <= 1'b0;
        end else begin
            lost_q <= (next_state == ST_LOST);
        end
    end

    assign sync_lost = lost_q;

endmodule

// File: rtl/frame_sync_aligner_chk.sv
module frame_sync_aligner_chk
    import fms_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick_en,
    input logic       fr_pps,
    input logic       fr_pulse,
    input logic       mf_pulse,
    input logic       sync_lost,
    input logic       sync_edge,
    input logic       load,
    input logic       timeout,
    input fms_state_t state_q
);

    // R2
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick_en) |-> ($stable(fr_pulse) && $stable(mf_pulse)));

    // R4
    mf_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_pulse && !fr_pps && $stable(fr_pps) && $past(tick_en)) |-> fr_pulse);

    // R4
    pps_frame_on_mf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_pulse && fr_pps && $stable(fr_pps) && $past(tick_en)) |-> mf_pulse);

    // R6
    reload_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && load) |=> (fr_pulse && mf_pulse));

    // R8
    loss_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && !sync_edge && state_q == ST_TRACK) |=> sync_lost);

    // R9
    edge_beats_deadline_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && sync_edge) |=> !sync_lost);

    // R10
    recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOST && sync_edge) |=> !sync_lost);

endmodule

bind frame_sync_aligner frame_sync_aligner_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .fr_pps    (fr_pps),
    .fr_pulse  (fr_pulse),
    .mf_pulse  (mf_pulse),
    .sync_lost (sync_lost),
    .sync_edge (sync_edge),
    .load      (load),
    .timeout   (timeout),
    .state_q   (state_q)
);

// File: tb/sim_frame_sync_aligner.sv
module sim_frame_sync_aligner;

    localparam int T   = 16;
    localparam int F   = 8;
    localparam int TOL = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       sync_in = 1'b0;
    logic [1:0] sync_rate = 2'd0;
    logic       fr_pps = 1'b0;
    logic       mf_pps = 1'b0;
    logic       fr_pulse, mf_pulse, sync_lost;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    int tick_mode = 0;

    typedef struct {
        int    at;
        logic  fr;
        logic  mf;
        logic  lost;
        string req;
    } exp_t;

    exp_t q[$];

    frame_sync_aligner #(
        .TICKS_PER_FRAME (T),
        .FRAMES_PER_SEC  (F),
        .SLACK_TICKS     (TOL)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .sync_in   (sync_in),
        .sync_rate (sync_rate),
        .fr_pps    (fr_pps),
        .mf_pps    (mf_pps),
        .fr_pulse  (fr_pulse),
        .mf_pulse  (mf_pulse),
        .sync_lost (sync_lost)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Tick generator: 0 = every cycle, 1 = even-numbered negedges, 2 = off.
    always @(negedge clk) begin
        case (tick_mode)
            0: tick_en = 1'b1;
            1: tick_en = (cyc % 2 == 0);
            default: tick_en = 1'b0;
        endcase
    end

    task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cycle %0d fr/mf/lost actual=%b expected=%b", req, cyc, act, exp);
        end
    endtask

    task automatic expect_at(int at, logic fr, logic mf, logic lost, string req);
        exp_t e;
        e.at = at; e.fr = fr; e.mf = mf; e.lost = lost; e.req = req;
        q.push_back(e);
    endtask

    // Monitor: pops expectations as their cycle comes up.
    always @(negedge clk) begin
        exp_t e;
        while (q.size() > 0 && q[0].at <= cyc) begin
            e = q.pop_front();
            if (e.at < cyc) begin
                total++;
                bad++;
                $display("FAIL %s expectation for cycle %0d missed, actual=none expected=checked", e.req, e.at);
            end else begin
                chk(e.req, {fr_pulse, mf_pulse, sync_lost}, {e.fr, e.mf, e.lost});
            end
        end
    end

    task automatic sync_at(int e);
        while (cyc != e - 1) @(negedge clk);
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
    endtask

    task automatic do_reset(logic [1:0] rate, logic fs, logic ms, output int r);
        rst_n = 1'b0;
        sync_in = 1'b0;
        sync_rate = rate;
        fr_pps = fs;
        mf_pps = ms;
        @(negedge clk);
        chk("R1", {fr_pulse, mf_pulse, sync_lost}, 3'b000);
        @(negedge clk);
        chk("R1", {fr_pulse, mf_pulse, sync_lost}, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;
        r = cyc;
    endtask

    initial begin
        int r, e0, e1, e2, ee;

        // 8 kHz sync, 8 kHz frame, 2 kHz multiframe
        do_reset(2'd0, 1'b0, 1'b0, r);
        e0 = r + 38;
        expect_at(r + 1,    1, 1, 0, "R1");
        expect_at(e0 - 1,   0, 0, 0, "R3");
        expect_at(e0,       1, 1, 0, "R6");
        expect_at(e0 + 1,   0, 0, 0, "R3");
        expect_at(e0 + 16,  1, 0, 0, "R4");
        expect_at(e0 + 32,  1, 0, 0, "R3");
        expect_at(e0 + 33,  0, 0, 0, "R7");
        expect_at(e0 + 47,  0, 0, 0, "R7");
        expect_at(e0 + 48,  1, 0, 0, "R7");
        expect_at(e0 + 64,  1, 1, 0, "R4");
        expect_at(e0 + 80,  1, 0, 0, "R3");
        expect_at(e0 + 81,  0, 0, 0, "R3");
        expect_at(e0 + 82,  1, 1, 0, "R7");
        expect_at(e0 + 97,  0, 0, 0, "R7");
        expect_at(e0 + 98,  1, 0, 0, "R7");
        expect_at(e0 + 100, 0, 0, 0, "R9");
        expect_at(e0 + 101, 1, 1, 0, "R9");
        expect_at(e0 + 119, 0, 0, 0, "R8");
        expect_at(e0 + 120, 0, 0, 1, "R8");
        expect_at(e0 + 133, 1, 0, 1, "R8");
        expect_at(e0 + 165, 1, 1, 1, "R8");
        expect_at(e0 + 166, 1, 1, 0, "R10");
        expect_at(e0 + 181, 0, 0, 0, "R10");
        expect_at(e0 + 182, 1, 0, 0, "R10");
        sync_at(e0);
        sync_at(e0 + 16);
        sync_at(e0 + 33);
        sync_at(e0 + 47);
        sync_at(e0 + 64);
        sync_at(e0 + 82);
        sync_at(e0 + 101);
        sync_at(e0 + 166);
        while (q.size() > 0) @(negedge clk);

        // 2 kHz sync, once-per-second frame, 2 kHz multiframe
        do_reset(2'd2, 1'b1, 1'b0, r);
        e1 = r + 10;
        expect_at(e1,       1, 1, 0, "R6");
        expect_at(e1 + 16,  0, 0, 0, "R3");
        expect_at(e1 + 64,  0, 1, 0, "R4");
        expect_at(e1 + 128, 1, 1, 0, "R3");
        expect_at(e1 + 175, 0, 0, 0, "R5");
        expect_at(e1 + 176, 1, 1, 0, "R5");
        expect_at(e1 + 192, 0, 0, 0, "R5");
        expect_at(e1 + 240, 0, 1, 0, "R5");
        sync_at(e1);
        sync_at(e1 + 64);
        sync_at(e1 + 128);
        sync_at(e1 + 176);
        sync_at(e1 + 240);
        while (q.size() > 0) @(negedge clk);

        // 1 PPS sync, 8 kHz frame, once-per-second multiframe
        do_reset(2'd3, 1'b0, 1'b1, r);
        e2 = r + 20;
        expect_at(e2,       1, 1, 0, "R6");
        expect_at(e2 + 64,  1, 0, 0, "R4");
        expect_at(e2 + 128, 1, 1, 0, "R4");
        expect_at(e2 + 192, 1, 1, 0, "R5");
        expect_at(e2 + 322, 0, 0, 0, "R8");
        expect_at(e2 + 323, 0, 0, 1, "R8");
        sync_at(e2);
        sync_at(e2 + 128);
        sync_at(e2 + 192);
        while (q.size() > 0) @(negedge clk);

        // Gated ticks: one tick every two cycles
        tick_mode = 2;
        do_reset(2'd0, 1'b0, 1'b0, r);
        do begin
            @(posedge clk);
            #1;
        end while ((cyc % 2 != 0) || (cyc < r + 4));
        ee = cyc;
        tick_mode = 1;
        expect_at(ee,      0, 0, 0, "R2");
        expect_at(ee + 1,  1, 1, 0, "R2");
        expect_at(ee + 2,  1, 1, 0, "R2");
        expect_at(ee + 3,  0, 0, 0, "R2");
        expect_at(ee + 33, 1, 0, 0, "R2");
        expect_at(ee + 34, 1, 0, 0, "R2");
        while (q.size() > 0) @(negedge clk);

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired at cycle %0d, actual=running expected=finished", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule